// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog that must be serviced inside a closing window at the end of each timeout period. After software arms it with a 32-bit start word, a down-counter runs from a value taken from a 12-bit preload field shifted left by 13 bits. To service the watchdog, software writes two 16-bit keys in a fixed order. The service is accepted only when the counter has entered the programmed final fraction of the period. A completed service outside that fraction is a fault. Running the counter down to zero is also a fault.

Each fault sets a sticky status flag. Depending on the reaction setting, the fault then gives either a single-cycle interrupt pulse meant for a non-maskable interrupt line, or a reset request that stays high until the system reset clears it. Once started, the watchdog cannot be stopped by software. Only the synchronous system reset returns it to idle. Software reaches the block over a simple 32-bit register bus: a write strobe, a read strobe, a byte address and write data. Read data is registered and appears one clock after the read strobe.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the counter reads 0, the arm register (0x90) reads 0, status (0x98) reads 0, the reaction register (0xA4) reads 0x5, the window register (0xA8) reads 0x50, and both fault outputs are low.
- R2: Only a write of exactly 0xA98559DA to 0x90 starts the watchdog. Any other value is ignored. Register 0x90 reads 0xA98559DA while running and 0 otherwise.
- R3: A start or an accepted service loads the counter with the 12-bit preload (0x94, read back as its low 12 bits) shifted left by 13. The counter (0xA0) then drops by one per clock.
- R4: Once running, the watchdog stays running. Later writes to 0x90 have no effect.
- R5: Service is 0xE51A then 0xA35C written to 0x9C. Any other key value, or 0xA35C written without the first key before it, is ignored, returns the sequence to its start and neither reloads nor faults.
- R6: Window codes in 0xA8 are 0x50 / 0x500 / 0x5000 / 0x50000 / 0x500000, giving an open window of the last 1/2, 1/4, 1/8, 1/16 or 1/32 of the period. A service is accepted when 0 < counter <= period >> k. Any other code leaves the whole period open.
- R7: A completed service while the counter is above the window threshold is a fault and does not reload the counter.
- R8: When the counter steps from 1 to 0, a fault is raised on that same clock. The counter then holds at 0, and a later service is ignored.
- R9: Status bit 1 is set by any fault and stays set until software writes 1 to bit 1 of 0x98.
- R10: Writing 0xA to 0xA4 selects a one-clock pulse on `nmi_o` per fault. Writing 0x5 selects a level on `rst_req_o` that holds until system reset. Other values are ignored.
- R11: The window register keeps the 24 bits written and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the counter time base |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after rd_en |
| nmi_o | output | 1 | One-cycle fault pulse when the interrupt reaction is selected |
| rst_req_o | output | 1 | Fault reset request level when the reset reaction is selected |

## Verification
On every cycle, the assertions check these properties:
- the run flag never falls;
- an expired counter stays at zero;
- an early service leaves the counter stepping down instead of reloading;
- the key sequence returns to its start after a service;
- the status flag stays sticky unless cleared;
- the reset request stays high once raised;
- a fault pulse is never wider than one clock.

Only the bench scenarios can show the rest:
- the exact reload values;
- where each window boundary falls for several window codes, including an unrecognised code;
- that wrong or out-of-order keys are ignored;
- the exact clock on which expiry fires;
- how the two reaction modes differ in their output shape.

// File: rtl/wdt_win_pkg.sv
// Shared constants and helpers for the windowed watchdog.
// Assumes an 8-bit byte address and a 32-bit data bus.
package wdt_win_pkg;

    localparam logic [31:0] ARM_WORD  = 32'hA985_59DA;
    localparam logic [31:0] SVC_KEY_A = 32'h0000_E51A;
    localparam logic [31:0] SVC_KEY_B = 32'h0000_A35C;
    localparam logic [31:0] REACT_NMI = 32'h0000_000A;
    localparam logic [31:0] REACT_RST = 32'h0000_0005;

    localparam logic [7:0] OFS_ARM   = 8'h90;
    localparam logic [7:0] OFS_PRE   = 8'h94;
    localparam logic [7:0] OFS_STS   = 8'h98;
    localparam logic [7:0] OFS_KEY   = 8'h9C;
    localparam logic [7:0] OFS_CNT   = 8'hA0;
    localparam logic [7:0] OFS_REACT = 8'hA4;
    localparam logic [7:0] OFS_WIN   = 8'hA8;

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_e;

    // Right-shift that turns the period into the window threshold; 0 = fully open.
    function automatic logic [2:0] win_shift(input logic [23:0] code);
        case (code)
            24'h00_0050: win_shift = 3'd1;
            24'h00_0500: win_shift = 3'd2;
            24'h00_5000: win_shift = 3'd3;
            24'h05_0000: win_shift = 3'd4;
            24'h50_0000: win_shift = 3'd5;
            default:     win_shift = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
// Two-step service key sequencer.
// Recognises first key then second key; anything else returns to idle.
// Assumes key_wr is a single-cycle write strobe to the key register.
module wdt_key_seq
    import wdt_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output logic        svc
);
    key_st_e st_q;

    // A service is requested when the second key lands while armed.
    assign svc = key_wr && (st_q == KEY_ARMED) && (key_data == SVC_KEY_B);

    // Sequencer state update on each key write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= KEY_IDLE;
        end else if (key_wr) begin
            st_q <= (key_data == SVC_KEY_A) ? KEY_ARMED : KEY_IDLE;
        end
    end

    AST_SVC_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (st_q == KEY_IDLE)); // R5

endmodule

// File: rtl/wdt_down_counter.sv
// Run flag, period down-counter and window comparator.
// The counter loads preload << SHIFT on start or accepted service.
// It stops at zero and reports early-service and expiry faults.
// Assumes the preload input is stable around the load edge.
module wdt_down_counter
    import wdt_win_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int SHIFT = 13,
    localparam int CNT_W = PRE_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             svc,
    input  logic [PRE_W-1:0] preload,
    input  logic [2:0]       win_sh,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             viol
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] thr;
    logic             in_win, svc_ok, viol_early, viol_exp;

    // Window threshold and fault conditions for this cycle.
    always_comb begin
        load_val   = {preload, {SHIFT{1'b0}}};
        thr        = (win_sh == 3'd0) ? {CNT_W{1'b1}} : (period_q >> win_sh);
        in_win     = (cnt != '0) && (cnt <= thr);
        svc_ok     = running && svc && in_win;
        viol_early = running && svc && (cnt != '0) && !in_win;
        viol_exp   = running && !svc_ok && (cnt == CNT_W'(1));
        viol       = viol_early || viol_exp;
    end

    // Run flag, counter and latched period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cnt      <= '0;
            period_q <= '0;
        end else if (!running) begin
            if (start) begin
                running  <= 1'b1;
                cnt      <= load_val;
                period_q <= load_val;
            end
        end else if (svc_ok) begin
            cnt      <= load_val;
            period_q <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R4
    AST_EXPIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == '0) |=> (cnt == '0)); // R8
    AST_EARLY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        viol_early |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R7
    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> !viol); // R10

endmodule

// File: rtl/wdt_regs.sv
// Register file and bus decode for the windowed watchdog.
// Holds preload, reaction mode, window code and the sticky fault flag.
// Read data is registered and returns zero when no read is requested.
module wdt_regs
    import wdt_win_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic             viol,
    output logic             start,
    output logic             key_wr,
    output logic [PRE_W-1:0] preload,
    output logic [2:0]       win_sh,
    output logic             mode_nmi,
    output logic             sts_viol,
    output logic [31:0]      rdata
);
    logic [23:0] win_q;
    logic [31:0] rd_mux;
    logic        sts_clr;

    // Write-side decode of strobes and window shift.
    always_comb begin
        start   = wr_en && (addr == OFS_ARM) && (wdata == ARM_WORD);
        key_wr  = wr_en && (addr == OFS_KEY);
        sts_clr = wr_en && (addr == OFS_STS) && wdata[1];
        win_sh  = win_shift(win_q);
    end

    // Read multiplexer over all visible registers.
    always_comb begin
        rd_mux = '0;
        case (addr)
            OFS_ARM:   rd_mux = running ? ARM_WORD : 32'h0;
            OFS_PRE:   rd_mux[PRE_W-1:0] = preload;
            OFS_STS:   rd_mux[1] = sts_viol;
            OFS_CNT:   rd_mux[CNT_W-1:0] = cnt;
            OFS_REACT: rd_mux = mode_nmi ? REACT_NMI : REACT_RST;
            OFS_WIN:   rd_mux[23:0] = win_q;
            default:   rd_mux = '0;
        endcase
    end

    // Register storage, sticky status and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload  <= '0;
            mode_nmi <= 1'b0;
            win_q    <= 24'h00_0050;
            sts_viol <= 1'b0;
            rdata    <= '0;
        end else begin
            if (wr_en && addr == OFS_PRE) preload <= wdata[PRE_W-1:0];
            if (wr_en && addr == OFS_WIN) win_q <= wdata[23:0];
            if (wr_en && addr == OFS_REACT) begin
                if (wdata == REACT_NMI)      mode_nmi <= 1'b1;
                else if (wdata == REACT_RST) mode_nmi <= 1'b0;
            end
            if (viol)         sts_viol <= 1'b1;
            else if (sts_clr) sts_viol <= 1'b0;
            rdata <= rd_en ? rd_mux : 32'h0;
        end
    end

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_viol && !sts_clr) |=> sts_viol); // R9

endmodule

// File: rtl/windowed_watchdog.sv
// Top of the windowed watchdog: registers, key sequencer, counter
// and the fault reaction stage (interrupt pulse or held reset request).
// Assumes single-clock operation with a synchronous active-low reset.
module windowed_watchdog
    import wdt_win_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int SHIFT = 13,
    localparam int CNT_W = PRE_W + SHIFT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        nmi_o,
    output logic        rst_req_o
);
    logic             start, key_wr, svc, running, viol, mode_nmi, sts_viol;
    logic [PRE_W-1:0] preload;
    logic [2:0]       win_sh;
    logic [CNT_W-1:0] cnt;

    wdt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .running(running), .cnt(cnt),
        .viol(viol), .start(start), .key_wr(key_wr), .preload(preload),
        .win_sh(win_sh), .mode_nmi(mode_nmi), .sts_viol(sts_viol),
        .rdata(rdata)
    );

    wdt_key_seq u_keys (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wdata),
        .svc(svc)
    );

    wdt_down_counter #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .svc(svc),
        .preload(preload), .win_sh(win_sh), .cnt(cnt),
        .running(running), .viol(viol)
    );

    // Fault reaction: one-clock pulse or held reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            nmi_o     <= viol && mode_nmi;
            rst_req_o <= rst_req_o || (viol && !mode_nmi);
        end
    end

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o); // R10
    AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> sts_viol); // R9

endmodule

// File: tb/windowed_watchdog_bench.sv
`timescale 1ns/1ps
module windowed_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nmi_o, rst_req_o;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, edge_ix = 0, t_rl = 0, per = 8192;
    logic        rd_seen = 1'b0;
    logic [31:0] q_exp[$];
    string       q_tag[$];
    bit          done = 0;

    windowed_watchdog u_windowed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) rd_seen <= rd_en;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected item per returned read.
    always @(negedge clk) begin
        if (rd_seen && q_exp.size() > 0) begin
            logic [31:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk(rdata === e, t, rdata, e);
        end
    end

    // Driver tasks: called at a negedge, fire on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); edge_ix = cyc;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        @(posedge clk); edge_ix = cyc;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_cnt(input string tag);
        int v;
        rd_en = 1'b1; addr = 8'hA0;
        @(posedge clk); edge_ix = cyc;
        v = per - (edge_ix - 1 - t_rl);
        if (v < 0) v = 0;
        q_exp.push_back(32'(v)); q_tag.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic service();
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
    endtask

    task automatic sys_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int cnt_now();
        return per - (cyc - 1 - t_rl);
    endfunction

    initial begin
        int pulses, at;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // Phase A: reset state, arming, keys, expiry with interrupt reaction
        chk(nmi_o == 0 && rst_req_o == 0, "R1 outputs low", {nmi_o, rst_req_o}, 0);
        rd(8'h90, 32'h0, "R1 arm reads 0");
        rd(8'h98, 32'h0, "R1 status 0");
        rd(8'hA0, 32'h0, "R1 counter 0");
        rd(8'hA4, 32'h5, "R1 reaction reset");
        rd(8'hA8, 32'h50, "R1 window 0x50");
        wr(8'h90, 32'h1234_5678);
        rd(8'h90, 32'h0, "R2 bad arm word ignored");
        rd(8'hA0, 32'h0, "R2 counter idle");
        wr(8'h94, 32'h000F_FFFF);
        rd(8'h94, 32'hFFF, "R3 preload 12 bits");
        wr(8'h94, 32'h1);
        wr(8'hA4, 32'hA);
        wr(8'hA4, 32'h3);
        rd(8'hA4, 32'hA, "R10 reaction nmi kept");
        wr(8'hA8, 32'h50);
        wr(8'h90, 32'hA985_59DA); t_rl = edge_ix; per = 8192;
        rd_cnt("R3 load value");
        rd(8'h90, 32'hA985_59DA, "R2 arm readback");
        rd_cnt("R3 decrement");
        wr(8'h90, 32'h0);
        rd(8'h90, 32'hA985_59DA, "R4 stays running");
        service();
        chk(nmi_o == 1, "R7 early service fault", nmi_o, 1);
        @(negedge clk);
        chk(nmi_o == 0, "R10 pulse one clock", nmi_o, 0);
        rd(8'h98, 32'h2, "R9 status set");
        rd_cnt("R7 no reload");
        wr(8'h98, 32'h2);
        rd(8'h98, 32'h0, "R9 cleared");
        repeat (4200) @(negedge clk);
        wr(8'h9C, 32'h1234);
        wr(8'h9C, 32'hA35C);
        chk(nmi_o == 0, "R5 lone second key", nmi_o, 0);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'h7777);
        wr(8'h9C, 32'hA35C);
        chk(nmi_o == 0, "R5 broken sequence", nmi_o, 0);
        rd_cnt("R5 no reload");
        rd(8'h98, 32'h0, "R5 no fault");
        service(); t_rl = edge_ix;
        chk(nmi_o == 0, "R6 in-window accepted", nmi_o, 0);
        rd_cnt("R6 reloaded");
        pulses = 0; at = -1;
        for (int i = 0; i < 8300; i++) begin
            @(negedge clk);
            if (nmi_o) begin pulses++; at = cyc - 1; end
        end
        chk(pulses == 1, "R8 one expiry pulse", 32'(pulses), 1);
        chk(at == t_rl + 8192, "R8 expiry clock", 32'(at), 32'(t_rl + 8192));
        chk(rst_req_o == 0, "R10 no reset in nmi mode", rst_req_o, 0);
        rd(8'hA0, 32'h0, "R8 holds zero");
        service();
        chk(nmi_o == 0, "R8 service after expiry ignored", nmi_o, 0);
        rd(8'hA0, 32'h0, "R8 still zero");
        // Phase B: reset reaction with quarter window
        sys_reset();
        chk(rst_req_o == 0, "R1 reset clears request", rst_req_o, 0);
        wr(8'h94, 32'h1);
        wr(8'hA8, 32'h500);
        wr(8'h90, 32'hA985_59DA); t_rl = edge_ix; per = 8192;
        repeat (5000) @(negedge clk);
        service();
        chk(rst_req_o == 1 && nmi_o == 0, "R10 reset level", {nmi_o, rst_req_o}, 1);
        repeat (100) @(negedge clk);
        chk(rst_req_o == 1, "R10 reset held", rst_req_o, 1);
        rd(8'h98, 32'h2, "R9 status set");
        rd(8'hA8, 32'h500, "R11 window readback");
        // Phase C: unknown code, narrow window, maximum preload
        sys_reset();
        wr(8'h94, 32'h1);
        wr(8'hA4, 32'hA);
        wr(8'hA8, 32'h7);
        wr(8'h90, 32'hA985_59DA); t_rl = edge_ix; per = 8192;
        service(); t_rl = edge_ix;
        chk(nmi_o == 0, "R6 unknown code fully open", nmi_o, 0);
        rd_cnt("R6 reload on open window");
        wr(8'hA8, 32'h50_0000);
        rd(8'hA8, 32'h50_0000, "R11 wide code readback");
        while (cnt_now() > 300) @(negedge clk);
        service();
        chk(nmi_o == 1, "R6 outside 1/32 window", nmi_o, 1);
        while (cnt_now() > 200) @(negedge clk);
        service(); t_rl = edge_ix;
        chk(nmi_o == 0, "R6 inside 1/32 window", nmi_o, 0);
        rd_cnt("R6 reload after narrow service");
        wr(8'h94, 32'hFFF);
        while (cnt_now() > 200) @(negedge clk);
        service(); t_rl = edge_ix; per = 33546240;
        rd_cnt("R3 maximum preload");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule